// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the page-load sequencer of a byte-wide reprogrammable memory and watches every byte-load write that reaches it. It picks out fixed multi-write unlock codes, built from a shared three-write prefix and, for some operations, a second three-write group. These codes switch software write protection on or off, enter or leave an identification mode, request a whole-array erase and lock one of the two 8 KB boot regions at either end of the address space. A write that belongs to no code opens an ordinary page-load window.

The decoder holds the protection flag, the identification flag and both boot-lock flags. It tells the page sequencer whether the open window may program, and it classifies every page byte as stored or dropped. With protection on, a page that was not preceded by the unlock prefix still opens a window, which gives a dummy busy period, but every byte in it is dropped. The sequencer reports the end of each program cycle through `cycle_done`, and protection changes take effect on that report.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, protection, identification mode, both locks, the load window, the permit and all pulse outputs are low.
- R2: The prefix AA to low address 5555, 55 to 2AAA, then A0 to 5555 opens a permitted load window. Protection rises at the `cycle_done` that closes this window and not earlier.
- R3: With protection on, a write outside any code opens a load window with `prog_permit` low. Each byte of that window pulses `byte_drop`, one cycle after its write, and never `byte_store`.
- R4: With protection off, a write outside any code opens a permitted window. Its bytes pulse `byte_store` unless they fall in a locked boot region.
- R5: The six writes AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 20/5555 open a permitted window. Protection falls at the `cycle_done` that closes it.
- R6: The prefix followed by 90/5555 sets `id_mode`. The prefix followed by F0/5555 clears it. Neither opens a load window.
- R7: After AA, 55, 80, AA, 55 and 40/5555, a write of 00 to full address 00000 sets `lock_lo`, and a write of FF to full address 3FFFF sets `lock_hi`. Locks stay set until reset. Any other pair at that point leaves both locks unchanged.
- R8: A page byte whose address bits [17:13] are all zero while `lock_lo` is set is dropped, and so is one whose bits [17:13] are all one while `lock_hi` is set, even in a permitted window.
- R9: AA, 55, 80, AA, 55, 10/5555 pulses `erase_go` for exactly one cycle when neither lock is set, and does not pulse it when either lock is set.
- R10: A pair that does not continue a partly matched code ends it. If that pair is AA/5555, it starts a new code. Otherwise it is handled as a write outside any code.
- R11: Command pairs are matched on address bits [14:0] only, so higher address bits do not prevent a match.
- R12: Writes that form part of a code never pulse `byte_store` or `byte_drop`. While a window is open, every write is a page byte until `cycle_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle byte-load write strobe |
| wr_addr | input | 18 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| cycle_done | input | 1 | Pulse from the sequencer at the end of a program cycle |
| load_active | output | 1 | A load window (real or dummy) is open |
| prog_permit | output | 1 | The open window is allowed to program |
| byte_store | output | 1 | Pulse: the last write is a page byte to be stored |
| byte_drop | output | 1 | Pulse: the last write is a page byte that is discarded |
| erase_go | output | 1 | Pulse: start a whole-array erase |
| prot_on | output | 1 | Software write protection active |
| id_mode | output | 1 | Identification mode active |
| lock_lo | output | 1 | Lower boot region locked |
| lock_hi | output | 1 | Upper boot region locked |

## Verification
A matcher stuck in the wrong step shows up in the cycle after the next write. A code byte then opens a window when it should not, or a page byte is classified as part of a code, so `load_active`, `byte_store` and `byte_drop` disagree with the expected values right away. A wrong pending protection change stays hidden until the `cycle_done` that closes the window, which is why `prot_on` is checked both before and after each close. Lock errors appear on the first page byte that targets a boot region, and the random pages aim bytes at both ends of the address space for that reason.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int CMP_W = 15;
  localparam logic [CMP_W-1:0] ADR_A = 15'h5555;
  localparam logic [CMP_W-1:0] ADR_B = 15'h2AAA;

  typedef enum logic [3:0] {
    TK_OTHER, TK_AA, TK_55, TK_A0, TK_90, TK_F0,
    TK_80, TK_20, TK_40, TK_10, TK_LLO, TK_LHI
  } tok_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_P1, ST_P2, ST_X3, ST_X4, ST_X5, ST_LOCKW, ST_PAGE
  } st_e;

  typedef struct packed {
    logic page_byte;
    logic open_plain;
    logic open_cmd;
    logic set_pend;
    logic clr_pend;
    logic id_on;
    logic id_off;
    logic erase;
    logic lk_lo;
    logic lk_hi;
    logic close;
  } act_t;
endpackage

// File: rtl/usd_token.sv
module usd_token
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output tok_e              tok
);
  logic [CMP_W-1:0] low;

  always_comb begin
    low = addr[CMP_W-1:0];
    tok = TK_OTHER;
    if (addr == '0 && data == 8'h00) begin
      tok = TK_LLO;
    end else if (addr == '1 && data == 8'hFF) begin
      tok = TK_LHI;
    end else if (low == ADR_A) begin
      case (data)
        8'hAA:   tok = TK_AA;
        8'hA0:   tok = TK_A0;
        8'h90:   tok = TK_90;
        8'hF0:   tok = TK_F0;
        8'h80:   tok = TK_80;
        8'h20:   tok = TK_20;
        8'h40:   tok = TK_40;
        8'h10:   tok = TK_10;
        default: tok = TK_OTHER;
      endcase
    end else if (low == ADR_B && data == 8'h55) begin
      tok = TK_55;
    end
  end
endmodule

// File: rtl/usd_seq.sv
module usd_seq
  import unlock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  tok_e tok,
  input  logic cycle_done,
  output logic in_page,
  output act_t act
);
  st_e  st_q, st_d;
  logic restart;

  always_comb begin
    st_d    = st_q;
    act     = '0;
    restart = 1'b0;
    if (st_q == ST_PAGE) begin
      if (cycle_done) begin
        st_d      = ST_IDLE;
        act.close = 1'b1;
      end else if (wr_valid) begin
        act.page_byte = 1'b1;
      end
    end else if (wr_valid) begin
      case (st_q)
        ST_IDLE: restart = 1'b1;
        ST_P1: if (tok == TK_55) st_d = ST_P2; else restart = 1'b1;
        ST_P2: begin
          case (tok)
            TK_A0: begin st_d = ST_PAGE; act.open_cmd = 1'b1; act.set_pend = 1'b1; end
            TK_90: begin st_d = ST_IDLE; act.id_on = 1'b1; end
            TK_F0: begin st_d = ST_IDLE; act.id_off = 1'b1; end
            TK_80: st_d = ST_X3;
            default: restart = 1'b1;
          endcase
        end
        ST_X3: if (tok == TK_AA) st_d = ST_X4; else restart = 1'b1;
        ST_X4: if (tok == TK_55) st_d = ST_X5; else restart = 1'b1;
        ST_X5: begin
          case (tok)
            TK_20: begin st_d = ST_PAGE; act.open_cmd = 1'b1; act.clr_pend = 1'b1; end
            TK_40: st_d = ST_LOCKW;
            TK_10: begin st_d = ST_IDLE; act.erase = 1'b1; end
            default: restart = 1'b1;
          endcase
        end
        ST_LOCKW: begin
          case (tok)
            TK_LLO: begin st_d = ST_IDLE; act.lk_lo = 1'b1; end
            TK_LHI: begin st_d = ST_IDLE; act.lk_hi = 1'b1; end
            default: restart = 1'b1;
          endcase
        end
        default: st_d = ST_IDLE;
      endcase
      if (restart) begin
        if (tok == TK_AA) begin
          st_d = ST_P1;
        end else begin
          st_d           = ST_PAGE;
          act.open_plain = 1'b1;
          act.page_byte  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign in_page = (st_q == ST_PAGE);
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BOOT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cycle_done,
  output logic              load_active,
  output logic              prog_permit,
  output logic              byte_store,
  output logic              byte_drop,
  output logic              erase_go,
  output logic              prot_on,
  output logic              id_mode,
  output logic              lock_lo,
  output logic              lock_hi
);
  localparam int REG_W = ADDR_W - BOOT_W;

  tok_e tok;
  act_t act;
  logic in_page;

  logic prot_q, prot_d, pset_q, pset_d, pclr_q, pclr_d;
  logic id_q, id_d, llo_q, llo_d, lhi_q, lhi_d;
  logic perm_q, perm_d, st_q, st_d, dr_q, dr_d, er_q, er_d;
  logic lk_hit, perm_now;
  logic [REG_W-1:0] region;

  usd_token #(.ADDR_W(ADDR_W)) u_tok (.addr(wr_addr), .data(wr_data), .tok(tok));

  usd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .tok(tok),
    .cycle_done(cycle_done), .in_page(in_page), .act(act)
  );

  always_comb begin
    region   = wr_addr[ADDR_W-1:BOOT_W];
    lk_hit   = (llo_q && region == '0) || (lhi_q && region == '1);
    perm_now = act.open_plain ? !prot_q : (act.open_cmd | perm_q);

    st_d = act.page_byte & perm_now & !lk_hit;
    dr_d = act.page_byte & !(perm_now & !lk_hit);
    er_d = act.erase & !llo_q & !lhi_q;

    pset_d = act.close ? 1'b0 : (pset_q | act.set_pend);
    pclr_d = act.close ? 1'b0 : (pclr_q | act.clr_pend);
    prot_d = prot_q;
    if (act.close) begin
      if (pset_q)      prot_d = 1'b1;
      else if (pclr_q) prot_d = 1'b0;
    end

    id_d = id_q;
    if (act.id_on)  id_d = 1'b1;
    if (act.id_off) id_d = 1'b0;

    llo_d = llo_q | act.lk_lo;
    lhi_d = lhi_q | act.lk_hi;

    perm_d = perm_q;
    if (act.open_cmd)        perm_d = 1'b1;
    else if (act.open_plain) perm_d = !prot_q;
    else if (act.close)      perm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0; pset_q <= 1'b0; pclr_q <= 1'b0;
      id_q   <= 1'b0; llo_q  <= 1'b0; lhi_q  <= 1'b0;
      perm_q <= 1'b0; st_q   <= 1'b0; dr_q   <= 1'b0; er_q <= 1'b0;
    end else begin
      prot_q <= prot_d; pset_q <= pset_d; pclr_q <= pclr_d;
      id_q   <= id_d;   llo_q  <= llo_d;  lhi_q  <= lhi_d;
      perm_q <= perm_d; st_q   <= st_d;   dr_q   <= dr_d;   er_q <= er_d;
    end
  end

  assign load_active = in_page;
  assign prog_permit = perm_q;
  assign byte_store  = st_q;
  assign byte_drop   = dr_q;
  assign erase_go    = er_q;
  assign prot_on     = prot_q;
  assign id_mode     = id_q;
  assign lock_lo     = llo_q;
  assign lock_hi     = lhi_q;
endmodule

// File: rtl/usd_checker.sv
module usd_checker #(
  parameter int ADDR_W = 18,
  parameter int BOOT_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cycle_done,
  input logic              byte_store,
  input logic              byte_drop,
  input logic              erase_go,
  input logic              prot_on,
  input logic              lock_lo,
  input logic              lock_hi
);
  AST_STORE_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_store && byte_drop)); // R3
  AST_BYTE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_store || byte_drop) |-> $past(wr_valid)); // R12
  AST_PROT_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on != $past(prot_on)) |-> $past(cycle_done)); // R2
  AST_LOCK_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lo |=> lock_lo); // R7
  AST_LOCK_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hi |=> lock_hi); // R7
  AST_ERASE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (!lock_lo && !lock_hi)); // R9
  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go); // R9
  AST_LOCKED_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_store |-> !($past(lock_lo) && $past(wr_addr[ADDR_W-1:BOOT_W]) == '0)); // R8
  AST_LOCKED_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_store |-> !($past(lock_hi) && $past(wr_addr[ADDR_W-1:BOOT_W]) == '1)); // R8
endmodule

bind unlock_seq_decoder usd_checker #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .cycle_done(cycle_done), .byte_store(byte_store), .byte_drop(byte_drop),
  .erase_go(erase_go), .prot_on(prot_on), .lock_lo(lock_lo), .lock_hi(lock_hi)
);

// File: tb/sim_unlock_seq_decoder.sv
`timescale 1ns/1ps
module sim_unlock_seq_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [17:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cycle_done = 1'b0;
  logic load_active, prog_permit, byte_store, byte_drop, erase_go;
  logic prot_on, id_mode, lock_lo, lock_hi;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  unlock_seq_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .cycle_done(cycle_done), .load_active(load_active),
    .prog_permit(prog_permit), .byte_store(byte_store), .byte_drop(byte_drop),
    .erase_go(erase_go), .prot_on(prot_on), .id_mode(id_mode),
    .lock_lo(lock_lo), .lock_hi(lock_hi)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic done();
    cycle_done = 1'b1;
    @(posedge clk); @(negedge clk);
    cycle_done = 1'b0;
  endtask

  task automatic prefix(input logic [7:0] cmd);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, cmd);
  endtask

  task automatic long_code(input logic [7:0] cmd);
    prefix(8'h80);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, cmd);
  endtask

  function automatic bit exp_store(logic [17:0] a, bit prot, bit llo, bit lhi);
    return !prot && !(llo && a[17:13] == 5'h00) && !(lhi && a[17:13] == 5'h1F);
  endfunction

  task automatic rand_pages(input bit prot);
    for (int p = 0; p < 5; p++) begin
      for (int b = 0; b < 4; b++) begin
        logic [17:0] a;
        logic [7:0]  d;
        bit e;
        a = 18'($urandom);
        d = 8'($urandom);
        if ($urandom % 3 == 0) a[17:13] = ($urandom % 2) ? 5'h1F : 5'h00;
        if (b == 0 && (a[14:0] == 15'h5555 || a == '0 || a == '1)) a[14:0] = 15'h0123;
        e = exp_store(a, prot, lock_lo, lock_hi);
        wr(a, d);
        chk("R4/R8 random store", byte_store, e);
        chk("R3/R8 random drop", byte_drop, !e);
      end
      done();
      chk("R12 window closed", load_active, 1'b0);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 prot", prot_on, 0); chk("R1 id", id_mode, 0);
    chk("R1 locks", lock_lo | lock_hi, 0); chk("R1 window", load_active, 0);
    chk("R1 pulses", byte_store | byte_drop | erase_go | prog_permit, 0);

    // R4 plain page, protection off
    wr(18'h01234, 8'h5A);
    chk("R4 store", byte_store, 1); chk("R4 window", load_active, 1); chk("R4 permit", prog_permit, 1);
    wr(18'h05555, 8'hAA);
    chk("R12 AA inside window is data", byte_store, 1);
    done(); chk("R4 closed", load_active, 0);

    // R2 enable protection
    wr(18'h05555, 8'hAA); chk("R12 code byte", byte_store | byte_drop, 0);
    wr(18'h02AAA, 8'h55); chk("R12 code byte", byte_store | byte_drop | load_active, 0);
    wr(18'h05555, 8'hA0);
    chk("R2 window", load_active, 1); chk("R2 permit", prog_permit, 1); chk("R12 A0", byte_store, 0);
    wr(18'h10000, 8'h11); chk("R2 store", byte_store, 1); chk("R2 prot pending", prot_on, 0);
    done(); chk("R2 prot set", prot_on, 1);

    // R3 protected plain write
    wr(18'h10200, 8'h22);
    chk("R3 drop", byte_drop, 1); chk("R3 no store", byte_store, 0);
    chk("R3 dummy window", load_active, 1); chk("R3 permit low", prog_permit, 0);
    wr(18'h10201, 8'h23); chk("R3 drop 2", byte_drop, 1);
    done(); chk("R3 prot kept", prot_on, 1);

    // R11 high address bits ignored
    wr(18'h35555, 8'hAA); wr(18'h1AAAA, 8'h55); wr(18'h25555, 8'hA0);
    chk("R11 window", prog_permit, 1);
    wr(18'h10300, 8'h33); chk("R11 store", byte_store, 1);
    done();

    // R6 identification
    prefix(8'h90); chk("R6 id on", id_mode, 1); chk("R6 no window", load_active, 0);
    prefix(8'hF0); chk("R6 id off", id_mode, 0);

    // R10 break and restart
    wr(18'h05555, 8'hAA); wr(18'h01234, 8'h33);
    chk("R10 break opens window", load_active, 1); chk("R10 break byte dropped", byte_drop, 1);
    done();
    wr(18'h05555, 8'hAA); wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
    chk("R10 restart", id_mode, 1);
    prefix(8'hF0);

    // R5 disable protection
    long_code(8'h20);
    chk("R5 window", prog_permit, 1); chk("R5 pending", prot_on, 1);
    wr(18'h10400, 8'h44); chk("R5 store", byte_store, 1);
    done(); chk("R5 prot cleared", prot_on, 0);

    // R9 erase unlocked
    long_code(8'h10); chk("R9 erase pulse", erase_go, 1);
    @(negedge clk); chk("R9 one cycle", erase_go, 0);

    // R7 lock break, then locks
    long_code(8'h40); wr(18'h00001, 8'h00);
    chk("R7 no lock", lock_lo, 0); chk("R10 plain after break", byte_store, 1);
    done();
    long_code(8'h40); wr(18'h00000, 8'h00);
    chk("R7 lock lo", lock_lo, 1); chk("R7 hi untouched", lock_hi, 0);
    long_code(8'h40); wr(18'h3FFFF, 8'hFF); chk("R7 lock hi", lock_hi, 1);

    // R8 locked regions
    wr(18'h00010, 8'h55); chk("R8 low locked", byte_drop, 1);
    wr(18'h20000, 8'h66); chk("R8 middle ok", byte_store, 1);
    wr(18'h3E000, 8'h77); chk("R8 high locked", byte_drop, 1);
    done();

    // R9 erase blocked
    long_code(8'h10); chk("R9 erase blocked", erase_go, 0);

    rand_pages(1'b0);
    prefix(8'hA0); wr(18'h10000, 8'h01); done();
    chk("R2 prot set again", prot_on, 1);
    rand_pages(1'b1);
    chk("R7 locks held", lock_lo & lock_hi, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule